// File: doc/BRIEF.md
# Half-Chip Code Phase Tracker with Programmable Slew

This block keeps the code position of one tracking channel, counted in half code chips. An 11-bit phase counter steps once on every half-chip enable from the code oscillator. The code generator's end-of-period pulse clears it and advances an 8-bit epoch count. A measurement strobe copies both counts into readout registers, so software sees a consistent snapshot.

To move the local replica along the code, software writes a slew amount: the number of half chips to stall. The slew is held pending until a trigger arrives. In update mode the trigger is the next end-of-period pulse. In preset mode it is the next measurement strobe. While the slew runs, the half-chip enable passed on to the code generator is blocked and the phase counter freezes. An internal remaining count falls by one per blocked enable. A test-mode write port can force the phase counter to any value.

All pins are plain control and status signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. Every strobe is a single-cycle pulse that the block accepts on the clock edge where it is high.

Top module: `code_phase_tracker`

## Requirements
- R1: With no slew running, each cycle with `half_tick` high raises the phase counter by one, and 2047 wraps to 0.
- R2: A cycle with `dump` high sets the phase counter to 0 and raises the epoch count by one modulo 256. It takes priority over a half-chip step and over a test load in the same cycle.
- R3: A cycle with `tic` high copies the phase counter (as it stood before that edge) into `cap_phase[10:0]` and the epoch count into `cap_epoch`. Bits 15..11 of `cap_phase` read 0, and both outputs hold their value between strobes. Both read 0 after reset.
- R4: A `tic` taken while `slewing` is high stores 0 in `cap_phase`.
- R5: A cycle with `wr_phase` high loads `wr_data` into the phase counter only when `test_mode` is 1. With `test_mode` at 0 the write is ignored.
- R6: A `wr_slew` write of a nonzero N arms a slew. With `preset_mode` at 0 (update mode), `slewing` rises in the cycle after the next `dump`. With `preset_mode` at 1 (preset mode), it rises in the cycle after the next `tic`.
- R7: While `slewing` is high, `gen_tick` stays low and the phase counter holds. `slewing` falls in the cycle after the N-th `half_tick` of the slew, and the counter steps again from then on.
- R8: A `wr_slew` write of 0 arms nothing. `slewing` stays low at the next trigger.
- R9: An armed slew runs once. Later triggers do not restart it unless `wr_slew` is written again.
- R10: The pulse that belongs to the other mode does not start a slew: `tic` in update mode, or `dump` in preset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Half-chip enable from the code oscillator |
| dump | input | 1 | End-of-code-period pulse from the code generator |
| tic | input | 1 | Measurement strobe |
| preset_mode | input | 1 | 0 = update mode, 1 = preset mode |
| test_mode | input | 1 | Enables direct loading of the phase counter |
| wr_slew | input | 1 | Write strobe for the slew amount |
| wr_phase | input | 1 | Write strobe for the phase counter test load |
| wr_data | input | 11 | Write data for both write strobes |
| gen_tick | output | 1 | Half-chip enable passed on to the code generator |
| slewing | output | 1 | High while a slew is running |
| cap_phase | output | 16 | Captured phase, bits 10..0 used, upper bits 0 |
| cap_epoch | output | 8 | Captured epoch count |

## Verification
The assertions assume that the code generator never produces `dump` while a slew is running, since its clock enable is blocked at that time. One property checks this assumption directly. The hold check also assumes that no test load lands during a slew. The random stimulus issues `dump` and `wr_phase` only when the bench's own model shows no slew remaining, while `tic`, `half_tick`, slew writes and mode changes arrive freely. Directed passes cover the counter wrap, an ignored test write, zero and nonzero slews in both modes, and a strobe taken during a slew.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic {
    CPC_MODE_UPDATE = 1'b0,
    CPC_MODE_PRESET = 1'b1
  } cpc_mode_e;
endpackage

// File: rtl/cpc_slew_ctrl.sv
module cpc_slew_ctrl
  import cpc_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset_mode,
  input  logic             dump,
  input  logic             tic,
  input  logic             half_tick,
  input  logic             wr_slew,
  input  logic [CNT_W-1:0] wr_data,
  output logic             slewing
);
  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] rem_q;
  logic             armed_q;
  logic             trig;
  logic             launch;
  cpc_mode_e        mode;

  assign mode = cpc_mode_e'(preset_mode);

  always_comb begin
    case (mode)
      CPC_MODE_PRESET: trig = tic;
      default:         trig = dump;
    endcase
  end

  assign launch  = armed_q & trig;
  assign slewing = |rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (launch) begin
      rem_q <= pend_q;
    end else if (half_tick && slewing) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      armed_q <= 1'b0;
    end else if (wr_slew) begin
      pend_q  <= wr_data;
      armed_q <= |wr_data;
    end else if (launch) begin
      armed_q <= 1'b0;
    end
  end

  p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slewing && half_tick && !launch) |=> (rem_q == $past(rem_q) - 1'b1));
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slew && wr_data == '0) |=> !armed_q);
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && pend_q != '0) |=> slewing);
  p_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !wr_slew) |=> !armed_q);
  p_no_dump_in_slew_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slewing |-> !dump);
endmodule

// File: rtl/cpc_phase_cnt.sv
module cpc_phase_cnt #(
  parameter int PHASE_W = 11,
  parameter int EPOCH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dump,
  input  logic               step,
  input  logic               load_en,
  input  logic [PHASE_W-1:0] load_val,
  output logic [PHASE_W-1:0] phase,
  output logic [EPOCH_W-1:0] epoch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (dump) begin
      phase <= '0;
    end else if (load_en) begin
      phase <= load_val;
    end else if (step) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epoch <= '0;
    end else if (dump) begin
      epoch <= epoch + 1'b1;
    end
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (phase == '0));
  p_epoch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (epoch == $past(epoch) + 1'b1));
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !dump) |=> (phase == $past(load_val)));
endmodule

// File: rtl/cpc_capture.sv
module cpc_capture #(
  parameter int PHASE_W = 11,
  parameter int EPOCH_W = 8,
  parameter int BUS_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tic,
  input  logic               slewing,
  input  logic [PHASE_W-1:0] phase,
  input  logic [EPOCH_W-1:0] epoch,
  output logic [BUS_W-1:0]   cap_phase,
  output logic [EPOCH_W-1:0] cap_epoch
);
  localparam int PAD_W = BUS_W - PHASE_W;

  logic [PHASE_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= '0;
      cap_epoch <= '0;
    end else if (tic) begin
      ph_q      <= slewing ? '0 : phase;
      cap_epoch <= epoch;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign cap_phase = {{PAD_W{1'b0}}, ph_q};
    end else begin : g_nopad
      assign cap_phase = ph_q[BUS_W-1:0];
    end
  endgenerate

  p_cap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tic && slewing) |=> (cap_phase == '0));
  p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tic |=> ($stable(cap_phase) && $stable(cap_epoch)));
  p_cap_epoch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tic |=> (cap_epoch == $past(epoch)));
endmodule

// File: rtl/code_phase_tracker.sv
module code_phase_tracker #(
  parameter int PHASE_W = 11,
  parameter int EPOCH_W = 8,
  parameter int BUS_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_tick,
  input  logic               dump,
  input  logic               tic,
  input  logic               preset_mode,
  input  logic               test_mode,
  input  logic               wr_slew,
  input  logic               wr_phase,
  input  logic [PHASE_W-1:0] wr_data,
  output logic               gen_tick,
  output logic               slewing,
  output logic [BUS_W-1:0]   cap_phase,
  output logic [EPOCH_W-1:0] cap_epoch
);
  logic [PHASE_W-1:0] phase;
  logic [EPOCH_W-1:0] epoch;
  logic               load_en;

  assign gen_tick = half_tick & ~slewing;
  assign load_en  = wr_phase & test_mode;

  cpc_slew_ctrl #(.CNT_W(PHASE_W)) u_slew (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset_mode(preset_mode),
    .dump       (dump),
    .tic        (tic),
    .half_tick  (half_tick),
    .wr_slew    (wr_slew),
    .wr_data    (wr_data),
    .slewing    (slewing)
  );

  cpc_phase_cnt #(.PHASE_W(PHASE_W), .EPOCH_W(EPOCH_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .dump    (dump),
    .step    (gen_tick),
    .load_en (load_en),
    .load_val(wr_data),
    .phase   (phase),
    .epoch   (epoch)
  );

  cpc_capture #(.PHASE_W(PHASE_W), .EPOCH_W(EPOCH_W), .BUS_W(BUS_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .tic      (tic),
    .slewing  (slewing),
    .phase    (phase),
    .epoch    (epoch),
    .cap_phase(cap_phase),
    .cap_epoch(cap_epoch)
  );

  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase && !test_mode && !dump && !half_tick) |=> $stable(phase));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slewing && !dump && !load_en) |=> $stable(phase));
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !slewing && !dump && !load_en) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: tb/test_code_phase_tracker.sv
`timescale 1ns/100ps
module test_code_phase_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_tick = 1'b0, dump = 1'b0, tic = 1'b0;
  logic        preset_mode = 1'b0, test_mode = 1'b0;
  logic        wr_slew = 1'b0, wr_phase = 1'b0;
  logic [10:0] wr_data = '0;
  logic        gen_tick, slewing;
  logic [15:0] cap_phase;
  logic [7:0]  cap_epoch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_phase = 0, m_epoch = 0, m_pend = 0, m_rem = 0, m_cp = 0, m_ce = 0;
  bit m_armed = 1'b0;

  always #2.5 clk = ~clk;

  code_phase_tracker i_code_phase_tracker (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .dump(dump), .tic(tic),
    .preset_mode(preset_mode), .test_mode(test_mode), .wr_slew(wr_slew),
    .wr_phase(wr_phase), .wr_data(wr_data), .gen_tick(gen_tick),
    .slewing(slewing), .cap_phase(cap_phase), .cap_epoch(cap_epoch)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_epoch = 0; m_pend = 0; m_rem = 0; m_cp = 0; m_ce = 0; m_armed = 0;
    end else begin
      bit trg, go;
      int n_rem;
      trg = preset_mode ? tic : dump;
      go  = m_armed && trg;
      if (tic) begin
        m_cp = (m_rem != 0) ? 0 : m_phase;
        m_ce = m_epoch;
      end
      n_rem = m_rem;
      if (go) n_rem = m_pend;
      else if (half_tick && m_rem != 0) n_rem = m_rem - 1;
      if (dump) begin
        m_phase = 0; m_epoch = (m_epoch + 1) % 256;
      end else if (wr_phase && test_mode) m_phase = wr_data;
      else if (half_tick && m_rem == 0) m_phase = (m_phase + 1) % 2048;
      if (wr_slew) begin
        m_pend = wr_data; m_armed = (wr_data != 0);
      end else if (go) m_armed = 0;
      m_rem = n_rem;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(gen_tick == (half_tick && m_rem == 0), "R7 gen_tick", gen_tick, half_tick && m_rem == 0);
      check(slewing == (m_rem != 0), "R6 R8 R9 R10 slewing", slewing, m_rem != 0);
      check(cap_phase == m_cp, "R1 R3 R4 cap_phase", cap_phase, m_cp);
      check(cap_epoch == m_ce, "R2 R3 cap_epoch", cap_epoch, m_ce);
    end
  end

  task automatic cyc(input bit ht, input bit dp, input bit tc, input bit ws, input bit wp, input int d);
    @(posedge clk); #1;
    half_tick = ht; dump = dp; tic = tc; wr_slew = ws; wr_phase = wp; wr_data = 11'(d);
  endtask

  task automatic settle();
    @(posedge clk); #1;
    half_tick = 0; dump = 0; tic = 0; wr_slew = 0; wr_phase = 0; wr_data = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    check(cap_phase == 0 && cap_epoch == 0 && !slewing, "R3 reset state", cap_phase, 0);

    // R1: wrap after a test load of 2046
    test_mode = 1;
    cyc(0,0,0,0,1,2046); cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0); cyc(0,0,1,0,0,0); settle();
    check(cap_phase == 0, "R1 wrap 2047 to 0", cap_phase, 0);
    for (int i = 0; i < 5; i++) cyc(1,0,0,0,0,0);
    cyc(0,0,1,0,0,0); settle();
    check(cap_phase == 5, "R1 count 5", cap_phase, 5);

    // R5: ignored without test mode, taken with it
    test_mode = 0;
    cyc(0,0,0,0,1,100); cyc(0,0,1,0,0,0); settle();
    check(cap_phase == 5, "R5 write ignored", cap_phase, 5);
    test_mode = 1;
    cyc(0,0,0,0,1,100); cyc(0,0,1,0,0,0); settle();
    check(cap_phase == 100, "R5 write taken", cap_phase, 100);

    // R2: dump clears, epoch increments, beats a same-cycle load and step
    cyc(1,1,0,0,1,300); cyc(0,0,1,0,0,0); settle();
    check(cap_phase == 0, "R2 dump clears phase", cap_phase, 0);
    check(cap_epoch == 1, "R2 epoch increments", cap_epoch, 1);
    test_mode = 0;

    // update mode slew of 3
    preset_mode = 0;
    cyc(0,0,0,1,0,3); cyc(0,0,1,0,0,0); settle();
    check(!slewing, "R10 tic in update mode", slewing, 0);
    cyc(0,1,0,0,0,0); settle();
    check(slewing, "R6 update slew starts after dump", slewing, 1);
    cyc(1,0,0,0,0,0); cyc(0,0,1,0,0,0); settle();
    check(cap_phase == 0 && cap_epoch == 2, "R4 tic during slew", cap_phase, 0);
    cyc(1,0,0,0,0,0); settle();
    check(slewing, "R7 still slewing after 2 ticks", slewing, 1);
    cyc(1,0,0,0,0,0); settle();
    check(!slewing, "R7 slew ends after 3 ticks", slewing, 0);
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0); cyc(0,0,1,0,0,0); settle();
    check(cap_phase == 2, "R7 counting resumes", cap_phase, 2);
    cyc(0,1,0,0,0,0); settle();
    check(!slewing, "R9 no second slew", slewing, 0);

    // preset mode
    preset_mode = 1;
    cyc(0,0,0,1,0,0); cyc(0,0,1,0,0,0); settle();
    check(!slewing, "R8 zero slew", slewing, 0);
    cyc(0,0,0,1,0,2); cyc(0,1,0,0,0,0); settle();
    check(!slewing, "R10 dump in preset mode", slewing, 0);
    cyc(0,0,1,0,0,0); settle();
    check(slewing, "R6 preset slew starts after tic", slewing, 1);
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0); settle();
    check(!slewing, "R7 preset slew ends", slewing, 0);

    // random traffic, with one long stretch without dump for wraps
    for (int k = 0; k < 12000; k++) begin
      @(posedge clk); #1;
      if (k % 700 == 0) preset_mode = $urandom % 2;
      if (k % 300 == 0) test_mode = $urandom % 2;
      half_tick = ($urandom % 4) != 0;
      dump      = (m_rem == 0) && (k < 4000 || k > 7000) && ($urandom % 40 == 0);
      tic       = ($urandom % 25 == 0);
      wr_slew   = ($urandom % 30 == 0);
      wr_phase  = (m_rem == 0) && ($urandom % 60 == 0);
      wr_data   = ($urandom % 3 == 0) ? 11'($urandom % 2048) : 11'($urandom % 12);
    end
    settle();
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule